// File: doc/BRIEF.md
# Stack Machine Arithmetic and Logic Unit

This block computes the arithmetic, bitwise, shift and comparison results of a small stack processor. The sequencer hands it one instruction byte with two operands already popped from the stack: `opA`, the item that sat second, and `opB`, the item that sat on top. The low five bits of the instruction pick the operation and bit 5 picks the width, byte or short. The block returns the value to push, with a flag that tells whether it is a byte or a short.

The work is split into a decoder, which turns the instruction byte into a struct of operation strobes plus a width flag, and a datapath. The datapath computes every result at full width on zero-extended operands, masks it to the selected width and registers it. A result appears one clock after the operation is presented with `opValid`, and it stays put while no operation is presented. Results wrap at the operand width. Division by zero yields zero. The shift takes one control byte that holds a left count in its high nibble and a right count in its low nibble, and it does the right shift first. The four comparisons always return a single byte, 01 or 00.

Top module: `stack_alu`

## Requirements
- R1: ADD returns opA+opB and SUB returns opA-opB (second minus top), both wrapping at the selected width (byte 02-03 gives ff; short 2000-1000 gives 1000).
- R2: MUL returns the low bits of opA*opB at the selected width (byte 02*ff gives fe; short 0800*0002 gives 1000).
- R3: DIV returns the unsigned quotient opA/opB rounded toward zero (byte 10/03 gives 05); a zero divisor at the selected width gives zero (short 0010/0000 gives 0000).
- R4: AND, ORA and EOR return the bitwise and, or and exclusive or of opA and opB (byte fc,3f gives 3c, ff, c3).
- R5: SFT shifts opA right by opB[3:0], then left by opB[7:4], and keeps the selected width. In short mode the value is 16 bits but the control is still only opB[7:0] (34 with 33 gives 30; short 1248 with 34 gives 0920).
- R6: EQU, NEQ, GTH and LTH compare opA with opB as unsigned numbers at the selected width. GTH is true when opA>opB and LTH when opA<opB. The result is 0001 for true and 0000 for false, with resWide low in both modes.
- R7: INC returns opB+1 at the selected width and wraps (short ffff gives 0000, byte ff gives 00).
- R8: In byte mode only opA[7:0] and opB[7:0] take part, result[15:8] is zero and resWide is low. resWide is high only for a short-mode operation that is not a comparison.
- R9: Operation codes are instr[4:0]: INC=01, EQU=08, NEQ=09, GTH=0a, LTH=0b, ADD=18, SUB=19, MUL=1a, DIV=1b, AND=1c, ORA=1d, EOR=1e, SFT=1f. instr[5]=1 selects short mode and instr[7:6] are ignored. Any other code gives result 0000 with resWide low.
- R10: The result registers are updated one clock after a cycle with opValid high, and resValid is high exactly in that next cycle. Without opValid the result and resWide hold their values. Reset clears resValid, result and resWide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| instr | input | 8 | Instruction byte: operation code in [4:0], short mode in bit 5 |
| opA | input | 16 | Second stack item |
| opB | input | 16 | Top stack item (shift control in [7:0]) |
| resValid | output | 1 | Result registered from the previous cycle's operation |
| result | output | 16 | Result value; byte results use the low 8 bits |
| resWide | output | 1 | High when result is a short |

## Verification
On every cycle the assertions check the output protocol: the valid bit follows the operation strobe by one cycle, the result holds between operations, and comparisons never produce more than a single 0/1 byte. They also check that byte-mode results keep their upper byte clear, that a zero divisor always gives zero, and that a short increment of ffff wraps to zero. The arithmetic values themselves need the bench's scenarios, which compare against expected values worked out from the requirements. These cover wraparound in subtraction and multiplication, truncating division, the nibble-split shift in both widths, unsigned ordering, unknown codes, ignored instruction bits, and garbage in the operands' upper bytes.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;

  localparam int OPC_W     = 5;
  localparam int SHORT_BIT = 5;

  localparam logic [OPC_W-1:0] OPC_INC = 5'h01;
  localparam logic [OPC_W-1:0] OPC_EQU = 5'h08;
  localparam logic [OPC_W-1:0] OPC_NEQ = 5'h09;
  localparam logic [OPC_W-1:0] OPC_GTH = 5'h0a;
  localparam logic [OPC_W-1:0] OPC_LTH = 5'h0b;
  localparam logic [OPC_W-1:0] OPC_ADD = 5'h18;
  localparam logic [OPC_W-1:0] OPC_SUB = 5'h19;
  localparam logic [OPC_W-1:0] OPC_MUL = 5'h1a;
  localparam logic [OPC_W-1:0] OPC_DIV = 5'h1b;
  localparam logic [OPC_W-1:0] OPC_AND = 5'h1c;
  localparam logic [OPC_W-1:0] OPC_ORA = 5'h1d;
  localparam logic [OPC_W-1:0] OPC_EOR = 5'h1e;
  localparam logic [OPC_W-1:0] OPC_SFT = 5'h1f;

  // One strobe per operation, at most one set; plus width and capture.
  typedef struct packed {
    logic capture;
    logic wide;
    logic doInc;
    logic doEqu;
    logic doNeq;
    logic doGth;
    logic doLth;
    logic doAdd;
    logic doSub;
    logic doMul;
    logic doDiv;
    logic doAnd;
    logic doOra;
    logic doEor;
    logic doSft;
  } aluStrobeT;

endpackage

// File: rtl/stack_alu_ctrl.sv
module stack_alu_ctrl
  import stack_alu_pkg::*;
(
  input  logic                 opValid,
  input  logic [SHORT_BIT:0]   instrLow,
  output aluStrobeT            strobe
);

  logic [OPC_W-1:0] opc;
  assign opc = instrLow[OPC_W-1:0];

  always_comb begin
    strobe         = '0;
    strobe.capture = opValid;
    strobe.wide    = instrLow[SHORT_BIT];
    case (opc)
      OPC_INC: strobe.doInc = 1'b1;
      OPC_EQU: strobe.doEqu = 1'b1;
      OPC_NEQ: strobe.doNeq = 1'b1;
      OPC_GTH: strobe.doGth = 1'b1;
      OPC_LTH: strobe.doLth = 1'b1;
      OPC_ADD: strobe.doAdd = 1'b1;
      OPC_SUB: strobe.doSub = 1'b1;
      OPC_MUL: strobe.doMul = 1'b1;
      OPC_DIV: strobe.doDiv = 1'b1;
      OPC_AND: strobe.doAnd = 1'b1;
      OPC_ORA: strobe.doOra = 1'b1;
      OPC_EOR: strobe.doEor = 1'b1;
      OPC_SFT: strobe.doSft = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/stack_alu_dp.sv
module stack_alu_dp
  import stack_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobeT         strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              resWide
);

  localparam int NARROW_W = DATA_W / 2;
  localparam int NIB_W    = NARROW_W / 2;

  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] aOp;
  logic [DATA_W-1:0] bOp;

  assign widthMask = strobe.wide ? {DATA_W{1'b1}}
                                 : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign aOp = opA & widthMask;
  assign bOp = opB & widthMask;

  // Arithmetic
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] diffVal;
  logic [DATA_W-1:0] prodVal;
  logic [DATA_W-1:0] quotVal;
  logic [DATA_W-1:0] incVal;
  logic              divByZero;

  assign sumVal    = aOp + bOp;
  assign diffVal   = aOp - bOp;
  assign prodVal   = aOp * bOp;
  assign divByZero = (bOp == '0);
  assign quotVal   = divByZero ? '0 : (aOp / bOp);
  assign incVal    = bOp + 1'b1;

  // Shift: right by low nibble first, then left by high nibble
  logic [NIB_W-1:0]  rightCnt;
  logic [NIB_W-1:0]  leftCnt;
  logic [DATA_W-1:0] rightVal;
  logic [DATA_W-1:0] sftVal;

  assign rightCnt = opB[NIB_W-1:0];
  assign leftCnt  = opB[NARROW_W-1:NIB_W];
  assign rightVal = aOp >> rightCnt;
  assign sftVal   = rightVal << leftCnt;

  // Unsigned comparison, single flag
  logic cmpEq;
  logic cmpGt;
  logic cmpLt;
  logic cmpBit;
  logic isCmp;

  assign cmpEq  = (aOp == bOp);
  assign cmpGt  = (aOp > bOp);
  assign cmpLt  = (aOp < bOp);
  assign isCmp  = strobe.doEqu | strobe.doNeq | strobe.doGth | strobe.doLth;
  assign cmpBit = (strobe.doEqu & cmpEq) | (strobe.doNeq & ~cmpEq) |
                  (strobe.doGth & cmpGt) | (strobe.doLth & cmpLt);

  // Strobe-selected OR mux
  logic [DATA_W-1:0] rawRes;
  logic              anyOp;

  always_comb begin
    rawRes = '0;
    rawRes |= {DATA_W{strobe.doAdd}} & sumVal;
    rawRes |= {DATA_W{strobe.doSub}} & diffVal;
    rawRes |= {DATA_W{strobe.doMul}} & prodVal;
    rawRes |= {DATA_W{strobe.doDiv}} & quotVal;
    rawRes |= {DATA_W{strobe.doInc}} & incVal;
    rawRes |= {DATA_W{strobe.doAnd}} & (aOp & bOp);
    rawRes |= {DATA_W{strobe.doOra}} & (aOp | bOp);
    rawRes |= {DATA_W{strobe.doEor}} & (aOp ^ bOp);
    rawRes |= {DATA_W{strobe.doSft}} & sftVal;
    rawRes |= {{(DATA_W-1){1'b0}}, isCmp & cmpBit};
  end

  assign anyOp = strobe.doAdd | strobe.doSub | strobe.doMul | strobe.doDiv |
                 strobe.doInc | strobe.doAnd | strobe.doOra | strobe.doEor |
                 strobe.doSft;

  logic [DATA_W-1:0] nextRes;
  logic              nextWide;

  assign nextRes  = rawRes & widthMask;
  assign nextWide = strobe.wide & anyOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
      resWide  <= 1'b0;
    end else begin
      resValid <= strobe.capture;
      if (strobe.capture) begin
        result  <= nextRes;
        resWide <= nextWide;
      end
    end
  end

endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        instr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              resWide
);

  aluStrobeT strobe;

  stack_alu_ctrl u_ctrl (
    .opValid  (opValid),
    .instrLow (instr[SHORT_BIT:0]),
    .strobe   (strobe)
  );

  stack_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .resValid (resValid),
    .result   (result),
    .resWide  (resWide)
  );

endmodule

// File: rtl/stack_alu_chk.sv
module stack_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [5:0]        instrLow,
  input logic [DATA_W-1:0] opB,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic              resWide
);

  localparam int NARROW_W = DATA_W / 2;

  logic bZero;
  assign bZero = instrLow[5] ? (opB == '0) : (opB[NARROW_W-1:0] == '0);

  // R10: valid follows the operation strobe by one cycle
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(result) && $stable(resWide)));

  // R6: comparisons yield a single 0/1 byte
  assert_cmp_byte_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && instrLow[4:2] == 3'b010) |=>
      (result[DATA_W-1:1] == '0 && !resWide));

  // R8: byte mode clears the upper byte
  assert_byte_upper_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !instrLow[5]) |=>
      (result[DATA_W-1:NARROW_W] == '0 && !resWide));

  // R3: zero divisor gives zero
  assert_div_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && instrLow[4:0] == 5'h1b && bZero) |=> (result == '0));

  // R7: short increment wraps
  assert_inc_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && instrLow == 6'h21 && (&opB)) |=> (result == '0 && resWide));

endmodule

bind stack_alu stack_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .instrLow (instr[5:0]),
  .opB      (opB),
  .resValid (resValid),
  .result   (result),
  .resWide  (resWide)
);

// File: tb/test_stack_alu.sv
module test_stack_alu;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [7:0]   instr = 8'h00;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         resValid;
  logic [W-1:0] result;
  logic         resWide;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stack_alu #(.DATA_W(W)) i_stack_alu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .instr(instr),
    .opA(opA), .opB(opB), .resValid(resValid), .result(result),
    .resWide(resWide)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         wide;
    string        tag;
  } expT;

  expT sb[$];

  function automatic void check(string tag, logic [W:0] act, logic [W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // Independent reference written from the requirements
  function automatic logic [W:0] refModel(logic [7:0] ins, logic [W-1:0] a, logic [W-1:0] b);
    int unsigned lim;
    int unsigned x;
    int unsigned y;
    int unsigned r;
    bit sh;
    bit cmp;
    sh = ins[5];
    lim = sh ? 32'h10000 : 32'h100;
    x = sh ? a : a[7:0];
    y = sh ? b : b[7:0];
    cmp = 1'b0;
    case (ins[4:0])
      5'h01: r = (y + 1) % lim;
      5'h08: begin r = (x == y); cmp = 1; end
      5'h09: begin r = (x != y); cmp = 1; end
      5'h0a: begin r = (x > y);  cmp = 1; end
      5'h0b: begin r = (x < y);  cmp = 1; end
      5'h18: r = (x + y) % lim;
      5'h19: r = (x + lim - y) % lim;
      5'h1a: r = (x * y) % lim;
      5'h1b: r = (y == 0) ? 0 : x / y;
      5'h1c: r = x & y;
      5'h1d: r = x | y;
      5'h1e: r = x ^ y;
      5'h1f: r = ((x >> b[3:0]) << b[7:4]) % lim;
      default: return '0;
    endcase
    return {sh & ~cmp, r[W-1:0]};
  endfunction

  task automatic sendExp(string tag, logic [7:0] ins, logic [W-1:0] a,
                         logic [W-1:0] b, logic [W-1:0] er, logic ew);
    expT e;
    @(negedge clk);
    opValid = 1'b1; instr = ins; opA = a; opB = b;
    e.res = er; e.wide = ew; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic sendModel(string tag, logic [7:0] ins, logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] m;
    m = refModel(ins, a, b);
    sendExp(tag, ins, a, b, m[W-1:0], m[W]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      opValid = 1'b0;
      opA = $urandom; opB = $urandom; instr = $urandom;
    end
  endtask

  // Monitor: pops expected items as results appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && resValid) begin
        if (sb.size() == 0) begin
          check("R10 unexpected resValid", {1'b0, 16'h0}, {1'b1, 16'h0});
        end else begin
          expT e;
          e = sb.pop_front();
          check(e.tag, {resWide, result}, {e.wide, e.res});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset state", {resWide, result}, 17'h0);
    check("R10 reset resValid", {16'h0, resValid}, 17'h0);
    @(negedge clk);
    rstN = 1'b1;

    sendExp("R1 add byte",   8'h18, 16'h001a, 16'h002e, 16'h0048, 1'b0);
    sendExp("R1 add short",  8'h38, 16'h0001, 16'h0002, 16'h0003, 1'b1);
    sendExp("R1 sub wrap",   8'h19, 16'h0002, 16'h0003, 16'h00ff, 1'b0);
    sendExp("R1 sub short",  8'h39, 16'h2000, 16'h1000, 16'h1000, 1'b1);
    sendExp("R2 mul byte",   8'h1a, 16'h0002, 16'h00ff, 16'h00fe, 1'b0);
    sendExp("R2 mul short",  8'h3a, 16'h0800, 16'h0002, 16'h1000, 1'b1);
    sendExp("R3 div trunc",  8'h1b, 16'h0010, 16'h0003, 16'h0005, 1'b0);
    sendExp("R3 div zero s", 8'h3b, 16'h0010, 16'h0000, 16'h0000, 1'b1);
    sendExp("R3 div zero b", 8'h1b, 16'h0077, 16'h1200, 16'h0000, 1'b0);
    sendExp("R4 and",        8'h1c, 16'h00fc, 16'h003f, 16'h003c, 1'b0);
    sendExp("R4 ora",        8'h1d, 16'h00fc, 16'h003f, 16'h00ff, 1'b0);
    sendExp("R4 eor",        8'h1e, 16'h00fc, 16'h003f, 16'h00c3, 1'b0);
    sendExp("R5 sft left",   8'h1f, 16'h0034, 16'h0010, 16'h0068, 1'b0);
    sendExp("R5 sft right",  8'h1f, 16'h0034, 16'h0001, 16'h001a, 1'b0);
    sendExp("R5 sft both",   8'h1f, 16'h0034, 16'h0033, 16'h0030, 1'b0);
    sendExp("R5 sft short",  8'h3f, 16'h1248, 16'hff34, 16'h0920, 1'b1);
    sendExp("R6 equ true",   8'h08, 16'h0012, 16'h0012, 16'h0001, 1'b0);
    sendExp("R6 equ2 false", 8'h28, 16'habcd, 16'hef01, 16'h0000, 1'b0);
    sendExp("R6 neq2 true",  8'h29, 16'habcd, 16'hef01, 16'h0001, 1'b0);
    sendExp("R6 gth true",   8'h0a, 16'h0034, 16'h0012, 16'h0001, 1'b0);
    sendExp("R6 gth2 false", 8'h2a, 16'h1234, 16'h3456, 16'h0000, 1'b0);
    sendExp("R6 lth unsig",  8'h0b, 16'h0001, 16'h0080, 16'h0001, 1'b0);
    sendExp("R6 lth2 false", 8'h2b, 16'h0001, 16'h0000, 16'h0000, 1'b0);
    sendExp("R7 inc byte",   8'h01, 16'h0000, 16'h0001, 16'h0002, 1'b0);
    sendExp("R7 inc2 wrap",  8'h21, 16'h5555, 16'hffff, 16'h0000, 1'b1);
    sendExp("R7 inc wrap b", 8'h01, 16'h0000, 16'h12ff, 16'h0000, 1'b0);
    sendExp("R8 byte high ignored", 8'h18, 16'h121a, 16'h342e, 16'h0048, 1'b0);
    sendExp("R9 ignored bits", 8'hd8, 16'h001a, 16'h002e, 16'h0048, 1'b0);
    sendExp("R9 unknown code", 8'h23, 16'h1234, 16'h5678, 16'h0000, 1'b0);
    sendExp("R9 unknown code2", 8'h06, 16'h00ff, 16'h00ff, 16'h0000, 1'b0);
    idle(1);

    // R10: hold while idle
    sendExp("R10 hold setup", 8'h38, 16'h1111, 16'h2222, 16'h3333, 1'b1);
    idle(4);
    @(posedge clk); #1;
    held = result;
    check("R10 result held", {resWide, held}, {1'b1, 16'h3333});
    check("R10 valid low idle", {16'h0, resValid}, 17'h0);

    // Mixed patterns against the reference
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ins;
      logic [4:0] pick;
      pick = 5'($urandom_range(0, 12));
      case (pick)
        5'd0: ins = 8'h01;  5'd1: ins = 8'h08;  5'd2: ins = 8'h09;
        5'd3: ins = 8'h0a;  5'd4: ins = 8'h0b;  5'd5: ins = 8'h18;
        5'd6: ins = 8'h19;  5'd7: ins = 8'h1a;  5'd8: ins = 8'h1b;
        5'd9: ins = 8'h1c;  5'd10: ins = 8'h1d; 5'd11: ins = 8'h1e;
        default: ins = 8'h1f;
      endcase
      ins[5] = $urandom_range(0, 1);
      ins[7:6] = 2'($urandom);
      sendModel("R1-mix R2 R3 R4 R5 R6 R7 R8 random", ins, 16'($urandom), 16'($urandom));
      if (i % 7 == 3) idle(1);
    end
    idle(3);
    repeat (3) @(posedge clk);
    if (sb.size() != 0)
      check("R10 drained", {1'b0, 16'(sb.size())}, 17'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule